// File: doc/BRIEF.md
# NAND Flash Host Bus Cycle Generator

This block sits between an on-chip controller and a parallel NAND flash bus. The controller hands it one request at a time over a valid/ready handshake: a command byte, an address byte, a data write word, a read burst of N bytes, or a wait for the device's ready line. For each request the block drives chip enable, the command and address latch lines, the write and read strobes and the direction of the I/O bus. In a read it samples the returned data at a programmed point after the read strobe falls.

Every strobe phase is a count of system clocks, set at run time. There are two full sets of counts, a nominal one and a relaxed one, and a one-bit select picks between them. The select and all counts are taken when a request is accepted, so a request runs to the end with the counts it started with. A one-cycle `done` pulse marks the end of every request, after the last high phase of the strobe has elapsed.

Top module: `nand_bus_seq`

## Requirements
- R1: A command request (op code 0) drives cle high and ale low while the request runs. The byte goes out on io bits 7:0 with the upper io bits at zero, and it is held unchanged when we_n rises.
- R2: An address request (op code 1) drives ale high and cle low, with the byte placed on the bus as in R1.
- R3: A data write request (op code 2) drives all DATA_W io bits from req_data, with cle and ale low.
- R4: In a write-type request, we_n stays low for wr_lo cycles and then high for wr_hi cycles, so ce_n is low for exactly wr_lo+wr_hi cycles. A count of 0 acts as 1.
- R5: cfg_relaxed=1 selects the relaxed set of counts and 0 selects the nominal set. The select is sampled when the request is accepted, and changing it while a request runs has no effect on that request.
- R6: A read request (op code 3) keeps io_oe low. Each byte holds re_n low for rd_lo cycles and then high for at least rd_hi cycles. io_oe is never high while re_n is low.
- R7: Each read byte is sampled from io_in at the rd_acc-th rising clock edge after the edge that drove re_n low. For the first byte of a burst the delay is max(rd_acc, ce_acc). The high phase is stretched until the sample is taken. rd_valid pulses for one cycle with the sampled value on rd_data.
- R8: A read burst moves req_len bytes, and a req_len of 0 moves one byte. Lengths up to 2112 are supported.
- R9: A wait request (op code 4) holds ce_n low for busy_dly cycles (0 acts as 1) and then waits until the two-flop-synchronized rb_n reads high. done rises no earlier than the third clock edge after rb_n rises.
- R10: done is a one-cycle pulse in the first cycle with ce_n high after a request. It can fall in the same cycle as the last rd_valid of a burst.
- R11: After reset ce_n, we_n and re_n are high, cle, ale, io_oe and done are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_op | input | 3 | Op code: 0 command, 1 address, 2 data write, 3 read burst, 4 wait |
| req_data | input | DATA_W | Byte or word to write |
| req_len | input | LEN_W | Read burst length in bytes |
| cfg_relaxed | input | 1 | Select the relaxed count set |
| cfg_nom_wr_lo | input | CNT_W | Nominal write strobe low cycles |
| cfg_nom_wr_hi | input | CNT_W | Nominal write strobe high cycles |
| cfg_nom_rd_lo | input | CNT_W | Nominal read strobe low cycles |
| cfg_nom_rd_hi | input | CNT_W | Nominal read strobe high cycles |
| cfg_nom_rd_acc | input | CNT_W | Nominal read-strobe-to-data cycles |
| cfg_nom_ce_acc | input | CNT_W | Nominal enable-to-data cycles |
| cfg_rlx_wr_lo | input | CNT_W | Relaxed write strobe low cycles |
| cfg_rlx_wr_hi | input | CNT_W | Relaxed write strobe high cycles |
| cfg_rlx_rd_lo | input | CNT_W | Relaxed read strobe low cycles |
| cfg_rlx_rd_hi | input | CNT_W | Relaxed read strobe high cycles |
| cfg_rlx_rd_acc | input | CNT_W | Relaxed read-strobe-to-data cycles |
| cfg_rlx_ce_acc | input | CNT_W | Relaxed enable-to-data cycles |
| cfg_busy_dly | input | CNT_W | Cycles before ready is watched in a wait |
| done | output | 1 | One-cycle end-of-request pulse |
| rd_valid | output | 1 | Read sample valid |
| rd_data | output | DATA_W | Sampled read word |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch line |
| nf_ale | output | 1 | Address latch line |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | DATA_W | Bus value driven out |
| nf_io_oe | output | 1 | Bus output enable |
| nf_io_in | input | DATA_W | Bus value from the device |
| nf_rb_n | input | 1 | Ready (high) or busy (low) from the device |

## Verification
The last data sample of a burst and the end-of-request pulse can land in the same cycle. This happens when the access delay runs past the programmed high phase, so the stretched high phase ends on the very edge that takes the sample. The bench sets up this case with short strobe counts and a longer access delay. It drives a valid value onto io_in only in the one cycle the sample must use, and expects rd_valid and done together on the final byte, with the right value and the right total enable time.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
  parameter int unsigned CNT_W = 8;

  typedef enum logic [2:0] {
    OP_CMD   = 3'd0,
    OP_ADDR  = 3'd1,
    OP_WDATA = 3'd2,
    OP_RDATA = 3'd3,
    OP_WAIT  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WLO, ST_WHI, ST_RLO, ST_RHI, ST_BDLY, ST_BWAIT
  } st_e;

  typedef struct packed {
    logic [CNT_W-1:0] wr_lo;
    logic [CNT_W-1:0] wr_hi;
    logic [CNT_W-1:0] rd_lo;
    logic [CNT_W-1:0] rd_hi;
    logic [CNT_W-1:0] rd_acc;
    logic [CNT_W-1:0] ce_acc;
  } tprof_t;

  // counter preload: a phase of v cycles, 0 treated as 1
  function automatic logic [CNT_W-1:0] preload(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction
endpackage

// File: rtl/nfb_timing_sel.sv
module nfb_timing_sel
  import nfb_pkg::*;
(
  input  tprof_t nom,
  input  tprof_t rlx,
  input  logic   use_rlx,
  output tprof_t sel
);
  always_comb begin
    sel = use_rlx ? rlx : nom;
  end
endmodule

// File: rtl/nfb_rb_sync.sv
module nfb_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_in,
  output logic rb_ready
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], rb_n_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign rb_ready = sh_q[STAGES-1];
endmodule

// File: rtl/nfb_cycle_fsm.sv
module nfb_cycle_fsm
  import nfb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  input  tprof_t            prof,
  input  logic [CNT_W-1:0]  busy_dly,
  input  logic              rb_ready,
  input  logic [DATA_W-1:0] io_in,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              io_oe,
  output logic [DATA_W-1:0] io_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);
  st_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  acc_q, acc_d;
  logic              smp_q, smp_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  op_e               op_q, op_d;
  logic [DATA_W-1:0] dat_q;
  tprof_t            prof_q;
  logic [DATA_W-1:0] rdat_q;
  logic              rdv_q, rdv_d;
  logic              done_q, done_d;
  logic              accept, cap;
  logic [CNT_W-1:0]  first_acc;
  logic [DATA_W-1:0] cmd_bus;
  logic              wr_phase;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign first_acc = (prof.rd_acc > prof.ce_acc) ? prof.rd_acc : prof.ce_acc;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    smp_d  = smp_q;
    rem_d  = rem_q;
    op_d   = op_q;
    rdv_d  = 1'b0;
    done_d = 1'b0;
    cap    = 1'b0;
    if ((st_q == ST_RLO || st_q == ST_RHI) && !smp_q) begin
      if (acc_q == '0) begin
        cap   = 1'b1;
        rdv_d = 1'b1;
        smp_d = 1'b1;
      end else begin
        acc_d = acc_q - CNT_W'(1);
      end
    end
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d  = op_e'(req_op);
          rem_d = (req_len == '0) ? LEN_W'(1) : req_len;
          case (op_e'(req_op))
            OP_CMD, OP_ADDR, OP_WDATA: begin
              st_d  = ST_WLO;
              cnt_d = preload(prof.wr_lo);
            end
            OP_RDATA: begin
              st_d  = ST_RLO;
              cnt_d = preload(prof.rd_lo);
              acc_d = preload(first_acc);
              smp_d = 1'b0;
            end
            OP_WAIT: begin
              st_d  = ST_BDLY;
              cnt_d = preload(busy_dly);
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      ST_WLO: begin
        if (cnt_q == '0) begin
          st_d  = ST_WHI;
          cnt_d = preload(prof_q.wr_hi);
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      ST_WHI: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      ST_RLO: begin
        if (cnt_q == '0) begin
          st_d  = ST_RHI;
          cnt_d = preload(prof_q.rd_hi);
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      ST_RHI: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (smp_q || cap) begin
          if (rem_q == LEN_W'(1)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            rem_d = rem_q - LEN_W'(1);
            st_d  = ST_RLO;
            cnt_d = preload(prof_q.rd_lo);
            acc_d = preload(prof_q.rd_acc);
            smp_d = 1'b0;
          end
        end
      end
      ST_BDLY: begin
        if (cnt_q == '0) st_d = ST_BWAIT;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      ST_BWAIT: begin
        if (rb_ready) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      acc_q  <= '0;
      smp_q  <= 1'b0;
      rem_q  <= '0;
      op_q   <= OP_CMD;
      rdv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      smp_q  <= smp_d;
      rem_q  <= rem_d;
      op_q   <= op_d;
      rdv_q  <= rdv_d;
      done_q <= done_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      dat_q  <= req_data;
      prof_q <= prof;
    end
    if (cap) rdat_q <= io_in;
  end

  generate
    if (DATA_W > CMD_W) begin : g_wide
      assign cmd_bus = {{(DATA_W-CMD_W){1'b0}}, dat_q[CMD_W-1:0]};
    end else begin : g_narrow
      assign cmd_bus = dat_q;
    end
  endgenerate

  assign wr_phase = (st_q == ST_WLO) || (st_q == ST_WHI);
  assign ce_n     = (st_q == ST_IDLE);
  assign we_n     = (st_q != ST_WLO);
  assign re_n     = (st_q != ST_RLO);
  assign cle      = wr_phase && (op_q == OP_CMD);
  assign ale      = wr_phase && (op_q == OP_ADDR);
  assign io_oe    = wr_phase;
  assign io_out   = !wr_phase ? '0 : (op_q == OP_WDATA) ? dat_q : cmd_bus;
  assign rd_data  = rdat_q;
  assign rd_valid = rdv_q;
  assign done     = done_q;

  // R1
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R1
  we_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (io_oe && $stable(io_out)));
  // R6
  oe_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_oe && !re_n));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  wait_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BWAIT && !rb_ready) |=> !done);
  // R7
  rd_valid_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!ce_n));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nfb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_relaxed,
  input  logic [CNT_W-1:0]  cfg_nom_wr_lo,
  input  logic [CNT_W-1:0]  cfg_nom_wr_hi,
  input  logic [CNT_W-1:0]  cfg_nom_rd_lo,
  input  logic [CNT_W-1:0]  cfg_nom_rd_hi,
  input  logic [CNT_W-1:0]  cfg_nom_rd_acc,
  input  logic [CNT_W-1:0]  cfg_nom_ce_acc,
  input  logic [CNT_W-1:0]  cfg_rlx_wr_lo,
  input  logic [CNT_W-1:0]  cfg_rlx_wr_hi,
  input  logic [CNT_W-1:0]  cfg_rlx_rd_lo,
  input  logic [CNT_W-1:0]  cfg_rlx_rd_hi,
  input  logic [CNT_W-1:0]  cfg_rlx_rd_acc,
  input  logic [CNT_W-1:0]  cfg_rlx_ce_acc,
  input  logic [CNT_W-1:0]  cfg_busy_dly,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [DATA_W-1:0] nf_io_out,
  output logic              nf_io_oe,
  input  logic [DATA_W-1:0] nf_io_in,
  input  logic              nf_rb_n
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rsync_q;
  logic                  arst_n;
  tprof_t                nom_p, rlx_p, act_p;
  logic                  rb_ready;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign arst_n = rsync_q[RST_STAGES-1];

  assign nom_p = '{wr_lo: cfg_nom_wr_lo, wr_hi: cfg_nom_wr_hi, rd_lo: cfg_nom_rd_lo,
                   rd_hi: cfg_nom_rd_hi, rd_acc: cfg_nom_rd_acc, ce_acc: cfg_nom_ce_acc};
  assign rlx_p = '{wr_lo: cfg_rlx_wr_lo, wr_hi: cfg_rlx_wr_hi, rd_lo: cfg_rlx_rd_lo,
                   rd_hi: cfg_rlx_rd_hi, rd_acc: cfg_rlx_rd_acc, ce_acc: cfg_rlx_ce_acc};

  nfb_timing_sel u_tsel (
    .nom     (nom_p),
    .rlx     (rlx_p),
    .use_rlx (cfg_relaxed),
    .sel     (act_p)
  );

  nfb_rb_sync #(.STAGES(2)) u_rbs (
    .clk      (clk),
    .rst_n    (arst_n),
    .rb_n_in  (nf_rb_n),
    .rb_ready (rb_ready)
  );

  nfb_cycle_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (arst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_data  (req_data),
    .req_len   (req_len),
    .prof      (act_p),
    .busy_dly  (cfg_busy_dly),
    .rb_ready  (rb_ready),
    .io_in     (nf_io_in),
    .ce_n      (nf_ce_n),
    .cle       (nf_cle),
    .ale       (nf_ale),
    .we_n      (nf_we_n),
    .re_n      (nf_re_n),
    .io_oe     (nf_io_oe),
    .io_out    (nf_io_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .done      (done)
  );
endmodule

// File: tb/nand_bus_seq_test.sv
module nand_bus_seq_test;
  localparam int DW = 16;
  localparam int LW = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, cfg_relaxed;
  logic [2:0] req_op;
  logic [DW-1:0] req_data, rd_data, nf_io_out, nf_io_in;
  logic [LW-1:0] req_len;
  logic [CW-1:0] n_wlo, n_whi, n_rlo, n_rhi, n_racc, n_cacc;
  logic [CW-1:0] r_wlo, r_whi, r_rlo, r_rhi, r_racc, r_cacc, busy_dly;
  logic done, rd_valid, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, nf_rb_n;

  nand_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .req_len(req_len), .cfg_relaxed(cfg_relaxed),
    .cfg_nom_wr_lo(n_wlo), .cfg_nom_wr_hi(n_whi), .cfg_nom_rd_lo(n_rlo),
    .cfg_nom_rd_hi(n_rhi), .cfg_nom_rd_acc(n_racc), .cfg_nom_ce_acc(n_cacc),
    .cfg_rlx_wr_lo(r_wlo), .cfg_rlx_wr_hi(r_whi), .cfg_rlx_rd_lo(r_rlo),
    .cfg_rlx_rd_hi(r_rhi), .cfg_rlx_rd_acc(r_racc), .cfg_rlx_ce_acc(r_cacc),
    .cfg_busy_dly(busy_dly), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
    .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus monitor and read-data model
  int we_run, ce_run, re_run, last_we_lo, last_ce_lo, last_re_lo;
  logic [DW-1:0] last_we_io;
  logic last_we_cle, last_we_ale, done_at_rise, coinc;
  int cap_idx, cap_err, oe_err, k, cur_idx, first_acc, nxt_acc;
  logic p_we, p_ce, p_re;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_we = 1; p_ce = 1; p_re = 1; we_run = 0; ce_run = 0; re_run = 0;
      k = 0; oe_err = 0; nf_io_in = 16'hDEAD;
    end else begin
      if (!nf_we_n) we_run++;
      else if (!p_we) begin
        last_we_lo = we_run; we_run = 0;
        last_we_io = nf_io_out; last_we_cle = nf_cle; last_we_ale = nf_ale;
      end
      if (!nf_ce_n) ce_run++;
      else if (!p_ce) begin last_ce_lo = ce_run; ce_run = 0; done_at_rise = done; end
      if (!nf_re_n) re_run++;
      else if (!p_re) begin last_re_lo = re_run; re_run = 0; end
      if (!nf_re_n && nf_io_oe) oe_err++;
      if (rd_valid) begin
        if (rd_data !== 16'(32'hA500 + cap_idx)) cap_err++;
        cap_idx++;
        if (done) coinc = 1;
      end
      if (!nf_re_n && p_re) begin k = 1; cur_idx++; end
      else k++;
      nf_io_in = (k == ((cur_idx == 0) ? first_acc : nxt_acc)) ?
                 16'(32'hA500 + cur_idx) : 16'hDEAD;
      p_we = nf_we_n; p_ce = nf_ce_n; p_re = nf_re_n;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [DW-1:0] d, input logic [LW-1:0] len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_data = d; req_len = len;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_nominal();
    cfg_relaxed = 0;
    n_wlo = 7; n_whi = 5; n_rlo = 7; n_rhi = 6; n_racc = 8; n_cacc = 12;
  endtask

  task automatic t_reset();
    chk("R11 ce_n", nf_ce_n, 1); chk("R11 we_n", nf_we_n, 1);
    chk("R11 re_n", nf_re_n, 1); chk("R11 cle/ale", nf_cle | nf_ale, 0);
    chk("R11 io_oe", nf_io_oe, 0); chk("R11 done", done, 0);
    chk("R11 req_ready", req_ready, 1);
  endtask

  task automatic t_write(input string tag, input logic [2:0] op, input logic [DW-1:0] d,
                         input int e_cle, input int e_ale, input logic [DW-1:0] e_io,
                         input int e_we_lo, input int e_ce);
    issue(op, d, 0);
    wait_done();
    chk({tag, " cle"}, last_we_cle, e_cle);
    chk({tag, " ale"}, last_we_ale, e_ale);
    chk({tag, " io at we rise"}, last_we_io, e_io);
    chk({tag, " R4 we low"}, last_we_lo, e_we_lo);
    chk({tag, " R4 ce low"}, last_ce_lo, e_ce);
    chk({tag, " R10 done"}, done_at_rise, 1);
  endtask

  task automatic t_read(input string tag, input int n, input int lenf, input int fa,
                        input int na, input int e_ce, input int e_re_lo);
    cur_idx = -1; cap_idx = 0; cap_err = 0; coinc = 0; first_acc = fa; nxt_acc = na;
    issue(3'd3, '0, LW'(lenf));
    wait_done();
    chk({tag, " R7 sample errors"}, cap_err, 0);
    chk({tag, " R8 bytes"}, cap_idx, n);
    chk({tag, " R6 ce low"}, last_ce_lo, e_ce);
    chk({tag, " R6 re low"}, last_re_lo, e_re_lo);
    chk({tag, " R10 done"}, done_at_rise, 1);
  endtask

  task automatic t_coincide();
    n_rlo = 2; n_rhi = 2; n_racc = 6; n_cacc = 6;
    t_read("R7 stretch", 2, 2, 6, 6, 12, 2);
    chk("R10 rd_valid with done", coinc, 1);
    n_racc = 2;
    t_read("R7 ce access", 2, 2, 6, 2, 10, 2);
    set_nominal();
  endtask

  task automatic t_long();
    n_rlo = 1; n_rhi = 1; n_racc = 1; n_cacc = 1;
    t_read("R8 full page", 2112, 2112, 1, 1, 4224, 1);
    set_nominal();
    t_read("R8 zero length", 1, 0, 12, 8, 13, 7);
  endtask

  task automatic t_zero_counts();
    n_wlo = 0; n_whi = 0;
    t_write("R4 zero", 3'd2, 16'h1234, 0, 0, 16'h1234, 1, 2);
    set_nominal();
  endtask

  task automatic t_latch();
    cfg_relaxed = 1;
    issue(3'd0, 16'h0090, 0);
    cfg_relaxed = 0;
    wait_done();
    chk("R5 latched we low", last_we_lo, 15);
    chk("R5 latched ce low", last_ce_lo, 20);
  endtask

  task automatic t_wait();
    int n;
    logic early;
    nf_rb_n = 1; busy_dly = 5;
    issue(3'd4, '0, 0);
    wait_done();
    chk("R9 ready wait ce low", last_ce_lo, 6);
    busy_dly = 10;
    issue(3'd4, '0, 0);
    @(negedge clk); nf_rb_n = 0;
    early = 0;
    repeat (30) begin @(negedge clk); if (done) early = 1; end
    chk("R9 no done while busy", early, 0);
    nf_rb_n = 1;
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk("R9 done after ready", n, 3);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_data = 0; req_len = 0;
    nf_rb_n = 1; busy_dly = 4;
    set_nominal();
    r_wlo = 15; r_whi = 5; r_rlo = 15; r_rhi = 5; r_racc = 15; r_cacc = 19;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write("R1 command", 3'd0, 16'hFF30, 1, 0, 16'h0030, 7, 12);
    t_write("R2 address", 3'd1, 16'hAB5C, 0, 1, 16'h005C, 7, 12);
    t_write("R3 data", 3'd2, 16'hC3A7, 0, 0, 16'hC3A7, 7, 12);
    cfg_relaxed = 1;
    t_write("R5 relaxed", 3'd0, 16'h0070, 1, 0, 16'h0070, 15, 20);
    t_read("R5 relaxed read", 3, 3, 19, 15, 60, 15);
    cfg_relaxed = 0;
    t_read("R6 nominal read", 4, 4, 12, 8, 52, 7);
    t_zero_counts();
    t_latch();
    t_coincide();
    t_long();
    t_wait();
    chk("R6 oe with re low", oe_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule